// File: doc/BRIEF.md
# SEU Test-Period Pulse Monitor

This block runs four 16-bit circular shift registers at full clock rate and reports whether they still agree, using four slow pulse lines. Two registers keep three copies of every bit and vote among them. The other two are built from plain single flip-flops. The content of one plain register is driven out on device pins, and the pin input that carries it back is compared against the other plain register. The I/O cells are therefore part of what is tested. At the start of every test period, all registers are loaded with a seed pattern. The pattern is one of four and is picked by a two-bit select. Between loads, each register rotates left by one position per clock.

Three comparison channels run on every cycle. Channel A compares the two voted registers. Channel B compares the two plain registers. Channel C compares the looped-back pins with the internal copy. Any mismatch during a period sets a sticky flag for that channel. When the period ends, a control pulse is always emitted. A channel pulse is emitted in the same cycle only if that channel stayed clean for the whole period. The flags then clear.

At the far end, a missing channel pulse next to a control pulse identifies an upset in that channel. A missing control pulse points at the timing logic itself. That logic (period counter, error flags and pulse registers) is triplicated with voting.

Top module: `seu_pulse_monitor`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `pulse_o` is 0 and `loop_o` holds the seed of the selected pattern.
- R2: Seeds for a 16-bit register, by `pat_sel_i` value: 0 gives 0x0001, 1 gives 0xFFFE, 2 gives 0x5555, and 3 gives 0x00FF.
- R3: Within a period, the register seen on `loop_o` rotates left by one bit on each clock. Bit 15 moves into bit 0.
- R4: Every PERIOD (256) clocks, all registers are reloaded from the seed of the `pat_sel_i` value present at that edge. A change of `pat_sel_i` in the middle of a period has no effect until that reload.
- R5: `pulse_o[0]` (control) is high for exactly one cycle. It first rises at the 256th rising edge after reset release and then repeats every 256 cycles. No channel pulse ever appears without it.
- R6: With no mismatch in a period, `pulse_o[1]` (A), `pulse_o[2]` (B) and `pulse_o[3]` (C) are all high together with the control pulse, so `pulse_o` equals 4'b1111.
- R7: If `loop_i` differs from `loop_o` in any cycle of a period, only `pulse_o[3]` is missing at that period's end, so `pulse_o` equals 4'b0111.
- R8: Error flags clear at each period boundary. A period with no mismatch yields 4'b1111 again, even if the previous period had one.
- R9: A mismatch in the last cycle of a period (the cycle ending at the reload edge) still suppresses that period's channel C pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (40 MHz) |
| rst_i | input | 1 | Synchronous reset, active high |
| pat_sel_i | input | 2 | Test pattern select, sampled at each reload |
| loop_i | input | WIDTH | Pin loopback return of `loop_o` |
| loop_o | output | WIDTH | Plain register content driven to pins |
| pulse_o | output | 4 | Bit 0 control pulse; bits 1..3 pass pulses for channels A, B, C |

## Verification
An upset in any shift register shows up only at the next period boundary. It appears as a missing channel pulse, up to 256 cycles after the faulty cycle, and never as a change in pulse timing. A wrong period counter moves or drops the control pulse, so the cycle index of every control pulse is checked against reset release. A flag that fails to clear, or that misses the final cycle, shows as a wrong pulse pattern in the period after an injected mismatch or in the period where it was injected. Corrupting the pin loopback is the only port-level way to create a mismatch, and it reveals all three outcomes.

// File: rtl/seu_mon_pkg.sv
package seu_mon_pkg;
  typedef enum logic [1:0] {
    PAT_WALK1 = 2'd0,
    PAT_WALK0 = 2'd1,
    PAT_ALT   = 2'd2,
    PAT_BYTE  = 2'd3
  } pat_e;

  // pulse line indices
  localparam int LINE_CTRL = 0;
  localparam int LINE_A    = 1;
  localparam int LINE_B    = 2;
  localparam int LINE_C    = 3;
  localparam int NUM_CH    = 3;
endpackage

// File: rtl/seu_voter.sv
module seu_voter #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  assign y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/seu_shift_reg.sv
module seu_shift_reg #(
  parameter int W         = 16,
  parameter bit REDUNDANT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] q_o
);
  localparam int COPIES = REDUNDANT ? 3 : 1;

  logic [W-1:0] cp_q [COPIES];
  logic [W-1:0] cur;
  logic [W-1:0] rot;

  function automatic logic [W-1:0] rotl1(input logic [W-1:0] v);
    return {v[W-2:0], v[W-1]};
  endfunction

  generate
    if (REDUNDANT) begin : g_vote
      seu_voter #(.W(W)) u_vote (
        .a_i(cp_q[0]), .b_i(cp_q[1]), .c_i(cp_q[2]), .y_o(cur)
      );
    end else begin : g_single
      assign cur = cp_q[0];
    end
  endgenerate

  assign rot = rotl1(cur);

  generate
    for (genvar i = 0; i < COPIES; i++) begin : g_copy
      always_ff @(posedge clk_i) begin
        if (rst_i || load_i) cp_q[i] <= seed_i;
        else                 cp_q[i] <= rot;
      end
    end
  endgenerate

  assign q_o = cur;
endmodule

// File: rtl/seu_period_ctr.sv
module seu_period_ctr #(
  parameter int PERIOD = 256
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic end_o
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q [3];
  logic [CW-1:0] cnt_v;
  logic [CW-1:0] cnt_nx;

  seu_voter #(.W(CW)) u_vote (
    .a_i(cnt_q[0]), .b_i(cnt_q[1]), .c_i(cnt_q[2]), .y_o(cnt_v)
  );

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c);
    return (c == LAST) ? '0 : CW'(c + 1'b1);
  endfunction

  assign cnt_nx = next_count(cnt_v);

  generate
    for (genvar i = 0; i < 3; i++) begin : g_cnt
      always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q[i] <= '0;
        else       cnt_q[i] <= cnt_nx;
      end
    end
  endgenerate

  assign end_o = (cnt_v == LAST);
endmodule

// File: rtl/seu_pulse_gen.sv
module seu_pulse_gen #(
  parameter int NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           end_i,
  input  logic [NCH-1:0] mis_i,
  output logic [NCH:0]   pulse_o
);
  logic [NCH-1:0] err_q [3];
  logic [NCH-1:0] err_v;
  logic [NCH:0]   pls_q [3];
  logic [NCH-1:0] err_acc;

  seu_voter #(.W(NCH)) u_err_vote (
    .a_i(err_q[0]), .b_i(err_q[1]), .c_i(err_q[2]), .y_o(err_v)
  );
  seu_voter #(.W(NCH+1)) u_pls_vote (
    .a_i(pls_q[0]), .b_i(pls_q[1]), .c_i(pls_q[2]), .y_o(pulse_o)
  );

  assign err_acc = err_v | mis_i;

  generate
    for (genvar i = 0; i < 3; i++) begin : g_copy
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          err_q[i] <= '0;
          pls_q[i] <= '0;
        end else if (end_i) begin
          err_q[i] <= '0;
          pls_q[i] <= {~err_acc, 1'b1};
        end else begin
          err_q[i] <= err_acc;
          pls_q[i] <= '0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/seu_pulse_monitor.sv
module seu_pulse_monitor
  import seu_mon_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int PERIOD = 256
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [1:0]       pat_sel_i,
  input  logic [WIDTH-1:0] loop_i,
  output logic [WIDTH-1:0] loop_o,
  output logic [3:0]       pulse_o
);
  localparam int PW = NUM_CH + 1;

  function automatic logic [WIDTH-1:0] seed_of(input logic [1:0] sel);
    logic [WIDTH-1:0] s;
    s = '0;
    case (pat_e'(sel))
      PAT_WALK1: s[0] = 1'b1;
      PAT_WALK0: begin s = '1; s[0] = 1'b0; end
      PAT_ALT:   for (int i = 0; i < WIDTH; i++) s[i] = (i % 2 == 0);
      PAT_BYTE:  for (int i = 0; i < WIDTH && i < 8; i++) s[i] = 1'b1;
      default:   s = '0;
    endcase
    return s;
  endfunction

  // named internal events
  logic              period_end;
  logic [WIDTH-1:0]  seed;
  logic [WIDTH-1:0]  tmr_a_q, tmr_b_q, sff_a_q, sff_b_q;
  logic [NUM_CH-1:0] mis_vec;
  logic [PW-1:0]     pulse_w;

  assign seed = seed_of(pat_sel_i);

  seu_period_ctr #(.PERIOD(PERIOD)) u_ctr (
    .clk_i(clk_i), .rst_i(rst_i), .end_o(period_end)
  );

  seu_shift_reg #(.W(WIDTH), .REDUNDANT(1'b1)) u_tmr_a (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(period_end), .seed_i(seed), .q_o(tmr_a_q)
  );
  seu_shift_reg #(.W(WIDTH), .REDUNDANT(1'b1)) u_tmr_b (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(period_end), .seed_i(seed), .q_o(tmr_b_q)
  );
  seu_shift_reg #(.W(WIDTH), .REDUNDANT(1'b0)) u_sff_a (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(period_end), .seed_i(seed), .q_o(sff_a_q)
  );
  seu_shift_reg #(.W(WIDTH), .REDUNDANT(1'b0)) u_sff_b (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(period_end), .seed_i(seed), .q_o(sff_b_q)
  );

  assign loop_o = sff_b_q;

  assign mis_vec[LINE_A-1] = (tmr_a_q != tmr_b_q);
  assign mis_vec[LINE_B-1] = (sff_a_q != sff_b_q);
  assign mis_vec[LINE_C-1] = (loop_i  != sff_a_q);

  seu_pulse_gen #(.NCH(NUM_CH)) u_pulse (
    .clk_i(clk_i), .rst_i(rst_i), .end_i(period_end), .mis_i(mis_vec), .pulse_o(pulse_w)
  );

  assign pulse_o = pulse_w;
endmodule

// File: rtl/seu_pulse_monitor_chk.sv
module seu_pulse_monitor_chk #(
  parameter int WIDTH  = 16,
  parameter int PERIOD = 256
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [1:0]       pat_sel_i,
  input logic [WIDTH-1:0] loop_i,
  input logic [WIDTH-1:0] loop_o,
  input logic [3:0]       pulse_o
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] chk_q;
  logic          started_q;
  logic          seen_q;
  logic          last_w;

  assign last_w = (chk_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      chk_q     <= '0;
      started_q <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      chk_q     <= last_w ? '0 : CW'(chk_q + 1'b1);
      started_q <= started_q | last_w;
      seen_q    <= last_w ? 1'b0 : (seen_q | (loop_i != loop_o));
    end
  end

  function automatic logic [WIDTH-1:0] exp_seed(input logic [1:0] sel);
    logic [WIDTH-1:0] one;
    logic [WIDTH-1:0] r;
    one = '0; one[0] = 1'b1;
    r = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (sel == 2'd2) r[i] = ~i[0];
      if (sel == 2'd3) r[i] = (i < 8);
    end
    if (sel == 2'd0) r = one;
    if (sel == 2'd1) r = ~one;
    return r;
  endfunction

  // R3
  rotate_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (chk_q != '0) |-> (loop_o == {$past(loop_o[WIDTH-2:0]), $past(loop_o[WIDTH-1])}));

  // R4
  reload_seed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (started_q && chk_q == '0) |-> (loop_o == exp_seed($past(pat_sel_i))));

  // R5
  ctrl_timing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o[0] == (started_q && chk_q == '0));

  // R5
  ctrl_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o[0] |=> !pulse_o[0]);

  // R5
  no_orphan_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|pulse_o[3:1]) |-> pulse_o[0]);

  // R6
  ab_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o[0] |-> (pulse_o[2:1] == 2'b11));

  // R7
  c_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o[0] |-> (pulse_o[3] == !$past(seen_q || (loop_i != loop_o))));
endmodule

bind seu_pulse_monitor seu_pulse_monitor_chk #(.WIDTH(WIDTH), .PERIOD(PERIOD)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .pat_sel_i(pat_sel_i),
  .loop_i(loop_i), .loop_o(loop_o), .pulse_o(pulse_o)
);

// File: tb/sim_seu_pulse_monitor.sv
module sim_seu_pulse_monitor;
  localparam int CLK_PERIOD = 25;
  localparam int W   = 16;
  localparam int PER = 256;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   sel = 2'd0;
  logic [W-1:0] inj = '0;
  logic [W-1:0] loop_o;
  logic [W-1:0] loop_i;
  logic [3:0]   pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign loop_i = loop_o ^ inj;

  seu_pulse_monitor #(.WIDTH(W), .PERIOD(PER)) u0 (
    .clk_i(clk), .rst_i(rst), .pat_sel_i(sel),
    .loop_i(loop_i), .loop_o(loop_o), .pulse_o(pulse)
  );

  function automatic logic [W-1:0] seed_tab(input logic [1:0] s);
    case (s)
      2'd0: return 16'h0001;
      2'd1: return 16'hFFFE;
      2'd2: return 16'h5555;
      default: return 16'h00FF;
    endcase
  endfunction

  function automatic logic [W-1:0] rot_by(input logic [W-1:0] v, input int n);
    logic [W-1:0] r;
    r = v;
    for (int i = 0; i < n; i++) r = {r[W-2:0], r[W-1]};
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst = 1'b1; sel = s; inj = '0;
    step(3);
    rst = 1'b0;
  endtask

  // R1, R2
  task automatic t_reset_seeds();
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      check("R1 pulse after reset", 32'(pulse), 32'h0);
      check("R2 seed after reset", 32'(loop_o), 32'(seed_tab(2'(s))));
    end
  endtask

  // R3
  task automatic t_rotate();
    do_reset(2'd3);
    step(1);
    check("R3 rotate 1", 32'(loop_o), 32'(rot_by(16'h00FF, 1)));
    step(4);
    check("R3 rotate 5", 32'(loop_o), 32'(rot_by(16'h00FF, 5)));
    step(12);
    check("R3 rotate 17 wraps msb", 32'(loop_o), 32'(rot_by(16'h00FF, 17)));
  endtask

  // R5, R6, R4
  task automatic t_period();
    int first = -1;
    do_reset(2'd0);
    for (int k = 1; k <= PER; k++) begin
      step(1);
      if (pulse != 4'h0 && first < 0) first = k;
    end
    check("R5 first control pulse edge", 32'(first), 32'(PER));
    check("R6 all pass pulses", 32'(pulse), 32'hF);
    check("R4 reload seed", 32'(loop_o), 32'h0001);
    step(1);
    check("R5 pulse one cycle wide", 32'(pulse), 32'h0);
    step(PER - 2);
    check("R5 quiet before next end", 32'(pulse), 32'h0);
    step(1);
    check("R5 second control pulse", 32'(pulse), 32'hF);
  endtask

  // R4
  task automatic t_sel_change();
    do_reset(2'd2);
    step(10);
    sel = 2'd1;
    step(1);
    check("R4 mid-period select ignored", 32'(loop_o), 32'(rot_by(16'h5555, 11)));
    step(PER - 11);
    check("R4 new select at reload", 32'(loop_o), 32'hFFFE);
  endtask

  // R7, R8
  task automatic t_inject();
    do_reset(2'd0);
    step(100);
    inj = 16'h0010;
    step(1);
    inj = '0;
    step(PER - 101);
    check("R7 channel C suppressed", 32'(pulse), 32'h7);
    step(PER);
    check("R8 clean period restores", 32'(pulse), 32'hF);
  endtask

  // R9
  task automatic t_last_cycle();
    do_reset(2'd2);
    step(PER - 1);
    check("R9 no pulse before end", 32'(pulse), 32'h0);
    inj = 16'h8000;
    step(1);
    inj = '0;
    check("R9 last-cycle mismatch counted", 32'(pulse), 32'h7);
    step(PER);
    check("R8 flags cleared after R9", 32'(pulse), 32'hF);
  endtask

  initial begin
    t_reset_seeds();
    t_rotate();
    t_period();
    t_sel_change();
    t_inject();
    t_last_cycle();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule